// File: doc/BRIEF.md
# Operating Mode Power Controller

This block decides which of five power modes a small controller core is in: active, standby, stop, watch and subactive. It watches two instruction strobes (a sleep request and a stop request), a timer-mode bit, a low-speed flag, a direct-transfer flag, the asynchronous reset and two classes of interrupt request. From these it drives the oscillator enables, three clock-gate enables (CPU, peripheral, time base), the CPU clock-source select and a request to float the I/O pins.

All mode changes and all gate-enable changes happen only at instruction-cycle boundaries. The block makes these boundaries itself from its base clock, one every `CYC_DIV` clocks. Instruction strobes are one clock wide and may come at any point in a cycle. They are held until the next boundary and then used. Interrupt inputs are levels and are sampled at the boundary. When the core moves back to active from a mode in which the main oscillator was off, the main oscillator turns on at once. The CPU clock stays gated until a programmable stabilisation count has run out.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, whatever mode came before, `mode_o` is active (codes: 0 active, 1 standby, 2 stop, 3 watch, 4 subactive), every oscillator and clock enable is 1, the clock select is 0 (main) and the high-impedance request is 0.
- R2: A sleep strobe in active mode leads to standby. In standby the CPU clock is gated, both oscillators and the peripheral and time-base clocks run, the clock select is 0 and the I/O is not floated.
- R3: Standby leaves for active when `irq_any_i` is 1 at a boundary. Sleep and stop strobes in standby have no effect.
- R4: A stop strobe in active mode with `timer_mode_i` = 0 leads to stop mode. The main oscillator and all three clocks are off, the sub oscillator stays on and `io_hiz_o` is 1. Neither interrupt input moves the block out of stop; only reset does, and `io_hiz_o` is 1 in no other mode.
- R5: A stop strobe in active mode with `timer_mode_i` = 1 leads to watch mode. The main oscillator, CPU clock and peripheral clock are off, the time-base clock and sub oscillator are on and the clock select is 1 (sub).
- R6: Watch mode is left only when `irq_wake_i` is 1 at a boundary; `irq_any_i` alone does nothing. The target is active when `low_speed_i` = 0 and subactive when it is 1.
- R7: In subactive mode the CPU clock is enabled with clock select 1. The main oscillator is off and the peripheral and time-base clocks run. Whenever the CPU clock is enabled, the oscillator its select points at is enabled.
- R8: A sleep or stop strobe in subactive mode leads to active when `direct_xfer_i` = 1 and `low_speed_i` = 0, and to watch in every other case.
- R9: `direct_xfer_i` has no effect outside subactive mode: a sleep strobe in active mode with it set still leads to standby.
- R10: A move from watch or subactive into active loads a wait counter with `stab_count_i`. The counter then falls by one each clock. The CPU clock stays gated until the first boundary at which the counter is already zero before that boundary's edge.
- R11: Boundaries fall every `CYC_DIV` clocks after reset. Mode and gate outputs change only on the clock edge that ends a boundary cycle. A strobe that arrives earlier in the cycle is held until that edge.
- R12: When sleep and stop strobes both arrive in the same instruction cycle in active mode, the stop strobe wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep instruction strobe, one clock |
| stop_i | input | 1 | Stop instruction strobe, one clock |
| timer_mode_i | input | 1 | Picks watch (1) or stop (0) on a stop strobe |
| low_speed_i | input | 1 | Low-speed flag: leave watch for subactive |
| direct_xfer_i | input | 1 | Direct-transfer flag, used only in subactive |
| irq_any_i | input | 1 | Any enabled interrupt request pending |
| irq_wake_i | input | 1 | Pending request from external interrupt 0 or timer A |
| stab_count_i | input | WAIT_W | Main-oscillator stabilisation wait, in clocks |
| mode_o | output | 3 | Current mode code |
| main_osc_en_o | output | 1 | Main oscillator enable |
| sub_osc_en_o | output | 1 | Sub oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| per_clk_en_o | output | 1 | Peripheral clock gate enable |
| tb_clk_en_o | output | 1 | Time-base clock gate enable |
| cpu_clk_sel_o | output | 1 | CPU clock source: 0 main, 1 sub |
| io_hiz_o | output | 1 | Request to float the I/O pins |

## Verification
The bench puts a strobe early in an instruction cycle and checks that nothing moves before the boundary. A design that acted on strobes at once would switch a clock gate mid-cycle, and one that dropped unlatched strobes would never leave active. It raises both interrupt classes in stop and only the general class in watch. A design that woke on the wrong class would leave a mode it must hold. It covers both direct-transfer outcomes from subactive, simultaneous sleep and stop, and a stabilisation count spanning two boundaries. A wrong wait would release the CPU clock before the main oscillator settles. Random traffic with occasional resets is compared each cycle with a model kept in the bench.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    PM_ACTIVE  = 3'd0,
    PM_STANDBY = 3'd1,
    PM_STOP    = 3'd2,
    PM_WATCH   = 3'd3,
    PM_SUB     = 3'd4
  } pmode_t;

  typedef struct packed {
    logic main_osc;
    logic sub_osc;
    logic cpu_clk;
    logic per_clk;
    logic tb_clk;
    logic sel_sub;
    logic io_hiz;
  } gate_t;

  // Mode transition taken at an instruction-cycle boundary.
  function automatic pmode_t pm_next(input pmode_t cur, input logic sl, input logic st,
                                     input logic tmode, input logic lson, input logic dton,
                                     input logic irq_any, input logic irq_wake);
    pmode_t nxt;
    nxt = cur;
    case (cur)
      PM_ACTIVE: begin
        if (st)      nxt = tmode ? PM_WATCH : PM_STOP;
        else if (sl) nxt = PM_STANDBY;
      end
      PM_STANDBY: if (irq_any) nxt = PM_ACTIVE;
      PM_STOP:    nxt = PM_STOP;
      PM_WATCH:   if (irq_wake) nxt = lson ? PM_SUB : PM_ACTIVE;
      PM_SUB:     if (st || sl) nxt = (dton && !lson) ? PM_ACTIVE : PM_WATCH;
      default:    nxt = PM_ACTIVE;
    endcase
    return nxt;
  endfunction

  // True when a move restarts the main oscillator for the CPU.
  function automatic logic needs_stab(input pmode_t cur, input pmode_t nxt);
    return (nxt == PM_ACTIVE) && ((cur == PM_WATCH) || (cur == PM_SUB));
  endfunction

  // Enables that belong to a mode; cpu_ok only matters in active.
  function automatic gate_t pm_gates(input pmode_t m, input logic cpu_ok);
    gate_t g;
    g = '0;
    case (m)
      PM_ACTIVE: begin
        g.main_osc = 1'b1; g.sub_osc = 1'b1; g.cpu_clk = cpu_ok;
        g.per_clk  = 1'b1; g.tb_clk  = 1'b1;
      end
      PM_STANDBY: begin
        g.main_osc = 1'b1; g.sub_osc = 1'b1; g.per_clk = 1'b1; g.tb_clk = 1'b1;
      end
      PM_STOP: begin
        g.sub_osc = 1'b1; g.io_hiz = 1'b1;
      end
      PM_WATCH: begin
        g.sub_osc = 1'b1; g.tb_clk = 1'b1; g.sel_sub = 1'b1;
      end
      PM_SUB: begin
        g.sub_osc = 1'b1; g.cpu_clk = 1'b1; g.per_clk = 1'b1;
        g.tb_clk  = 1'b1; g.sel_sub = 1'b1;
      end
      default: begin
        g.main_osc = 1'b1; g.sub_osc = 1'b1; g.cpu_clk = 1'b1;
        g.per_clk  = 1'b1; g.tb_clk  = 1'b1;
      end
    endcase
    return g;
  endfunction

endpackage

// File: rtl/pwr_cycle_tick.sv
module pwr_cycle_tick #(
  parameter int CYC_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   sleep_i,
  input  logic   stop_i,
  input  logic   tmode_i,
  input  logic   lson_i,
  input  logic   dton_i,
  input  logic   irq_any_i,
  input  logic   irq_wake_i,
  output pmode_t mode_q,
  output pmode_t mode_nxt,
  output logic   load_wait
);
  logic pend_sleep_q, pend_stop_q;
  logic sleep_eff, stop_eff;

  assign sleep_eff = pend_sleep_q | sleep_i;
  assign stop_eff  = pend_stop_q  | stop_i;

  assign mode_nxt  = tick ? pm_next(mode_q, sleep_eff, stop_eff, tmode_i, lson_i,
                                    dton_i, irq_any_i, irq_wake_i)
                          : mode_q;
  assign load_wait = tick && needs_stab(mode_q, mode_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_sleep_q <= 1'b0;
      pend_stop_q  <= 1'b0;
    end else if (tick) begin
      pend_sleep_q <= 1'b0;
      pend_stop_q  <= 1'b0;
    end else begin
      pend_sleep_q <= sleep_eff;
      pend_stop_q  <= stop_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_ACTIVE;
    else        mode_q <= mode_nxt;
  end

  assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mode_q));

  assert_stop_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_STOP) |=> (mode_q == PM_STOP));

  assert_watch_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_WATCH && mode_nxt != PM_WATCH) |-> irq_wake_i);

  assert_standby_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_STANDBY && mode_nxt != PM_STANDBY) |-> (irq_any_i && mode_nxt == PM_ACTIVE));

endmodule

// File: rtl/pwr_stab_wait.sv
module pwr_stab_wait #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  output logic              done
);
  logic [WAIT_W-1:0] wait_q;

  assign done = (wait_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wait_q <= '0;
    else if (load)  wait_q <= load_val;
    else if (!done) wait_q <= wait_q - 1'b1;
  end

  assert_wait_falls_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !done) |=> (wait_q == $past(wait_q) - 1'b1));

  assert_wait_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (wait_q == $past(load_val)));

endmodule

// File: rtl/pwr_gate_reg.sv
module pwr_gate_reg
  import pwr_mode_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  pmode_t mode_nxt,
  input  logic   cpu_ok,
  output gate_t  gate_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gate_q <= pm_gates(PM_ACTIVE, 1'b1);
    else if (tick) gate_q <= pm_gates(mode_nxt, cpu_ok);
  end

  assert_gate_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(gate_q));

  assert_cpu_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q.cpu_clk |-> (gate_q.sel_sub ? gate_q.sub_osc : gate_q.main_osc));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int CYC_DIV = 4,
  parameter int WAIT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic              stop_i,
  input  logic              timer_mode_i,
  input  logic              low_speed_i,
  input  logic              direct_xfer_i,
  input  logic              irq_any_i,
  input  logic              irq_wake_i,
  input  logic [WAIT_W-1:0] stab_count_i,
  output logic [2:0]        mode_o,
  output logic              main_osc_en_o,
  output logic              sub_osc_en_o,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              tb_clk_en_o,
  output logic              cpu_clk_sel_o,
  output logic              io_hiz_o
);
  logic   tick;
  logic   load_wait;
  logic   wait_done;
  logic   cpu_ok;
  pmode_t mode_q;
  pmode_t mode_nxt;
  gate_t  gate_q;

  pwr_cycle_tick #(.CYC_DIV(CYC_DIV)) u_tick (
    .clk (clk), .rst_n (rst_n), .tick (tick)
  );

  pwr_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .sleep_i    (sleep_i),
    .stop_i     (stop_i),
    .tmode_i    (timer_mode_i),
    .lson_i     (low_speed_i),
    .dton_i     (direct_xfer_i),
    .irq_any_i  (irq_any_i),
    .irq_wake_i (irq_wake_i),
    .mode_q     (mode_q),
    .mode_nxt   (mode_nxt),
    .load_wait  (load_wait)
  );

  pwr_stab_wait #(.WAIT_W(WAIT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_wait),
    .load_val (stab_count_i),
    .done     (wait_done)
  );

  assign cpu_ok = !load_wait && wait_done;

  pwr_gate_reg u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .mode_nxt (mode_nxt),
    .cpu_ok   (cpu_ok),
    .gate_q   (gate_q)
  );

  assign mode_o        = mode_q;
  assign main_osc_en_o = gate_q.main_osc;
  assign sub_osc_en_o  = gate_q.sub_osc;
  assign cpu_clk_en_o  = gate_q.cpu_clk;
  assign per_clk_en_o  = gate_q.per_clk;
  assign tb_clk_en_o   = gate_q.tb_clk;
  assign cpu_clk_sel_o = gate_q.sel_sub;
  assign io_hiz_o      = gate_q.io_hiz;

  assert_hiz_only_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    io_hiz_o |-> (mode_o == 3'd2));

  assert_sub_no_main_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4) |-> (!main_osc_en_o && cpu_clk_sel_o));

endmodule

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CYC        = 4;
  localparam int WW         = 8;
  localparam int WD_LIMIT   = 150000;

  logic clk, rst_n;
  logic sleep_s, stop_s, tmode, lson, dton, irq_a, irq_w;
  logic [WW-1:0] stab;
  logic [2:0] mode_o;
  logic main_o, sub_o, cpu_o, per_o, tb_o, sel_o, hiz_o;

  int n_chk = 0, n_fail = 0, n_cyc = 0;

  pwr_mode_ctrl #(.CYC_DIV(CYC), .WAIT_W(WW)) dut (
    .clk (clk), .rst_n (rst_n), .sleep_i (sleep_s), .stop_i (stop_s),
    .timer_mode_i (tmode), .low_speed_i (lson), .direct_xfer_i (dton),
    .irq_any_i (irq_a), .irq_wake_i (irq_w), .stab_count_i (stab),
    .mode_o (mode_o), .main_osc_en_o (main_o), .sub_osc_en_o (sub_o),
    .cpu_clk_en_o (cpu_o), .per_clk_en_o (per_o), .tb_clk_en_o (tb_o),
    .cpu_clk_sel_o (sel_o), .io_hiz_o (hiz_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model, written from the requirements.
  function automatic logic [2:0] ref_next(input logic [2:0] cur, input bit sl, input bit st,
      input bit tm, input bit ls, input bit dt, input bit ia, input bit iw);
    logic [2:0] r;
    r = cur;
    if (cur == 3'd0) begin
      if (st) r = tm ? 3'd3 : 3'd2;
      else if (sl) r = 3'd1;
    end else if (cur == 3'd1) begin
      if (ia) r = 3'd0;
    end else if (cur == 3'd3) begin
      if (iw) r = ls ? 3'd4 : 3'd0;
    end else if (cur == 3'd4) begin
      if (sl || st) r = (dt && !ls) ? 3'd0 : 3'd3;
    end
    return r;
  endfunction

  // {main, sub, cpu, per, tb, sel, hiz}
  function automatic logic [6:0] ref_gates(input logic [2:0] m, input bit ok);
    case (m)
      3'd1:    return 7'b1101100;
      3'd2:    return 7'b0100001;
      3'd3:    return 7'b0100110;
      3'd4:    return 7'b0111110;
      default: return {2'b11, ok, 4'b1100};
    endcase
  endfunction

  int m_cnt, m_wait;
  logic [2:0] m_mode, m_nx;
  logic [6:0] m_g;
  bit m_ps, m_pt, m_tk, m_ld, m_ok;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_wait = 0; m_mode = 3'd0; m_ps = 0; m_pt = 0;
      m_g = ref_gates(3'd0, 1'b1);
    end else begin
      m_tk = (m_cnt == CYC - 1);
      m_ld = 1'b0;
      if (m_tk) begin
        m_nx = ref_next(m_mode, m_ps | sleep_s, m_pt | stop_s, tmode, lson, dton, irq_a, irq_w);
        m_ld = (m_nx == 3'd0) && (m_mode == 3'd3 || m_mode == 3'd4);
        m_ok = !m_ld && (m_wait == 0);
        m_g = ref_gates(m_nx, m_ok);
        m_mode = m_nx;
        m_ps = 0; m_pt = 0;
      end else begin
        m_ps = m_ps | sleep_s;
        m_pt = m_pt | stop_s;
      end
      if (m_ld) m_wait = int'(stab);
      else if (m_wait > 0) m_wait = m_wait - 1;
      m_cnt = m_tk ? 0 : m_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] dut_g();
    return {main_o, sub_o, cpu_o, per_o, tb_o, sel_o, hiz_o};
  endfunction

  // Per-cycle comparison against the model (R11 timing of every change).
  always @(negedge clk) begin
    if (rst_n) chk("R11 model", {22'd0, mode_o, dut_g()}, {22'd0, m_mode, m_g});
  end

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > WD_LIMIT) begin
      n_fail++;
      $display("FAIL watchdog R11 actual=%0d expected<=%0d cycles", n_cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic to_boundary();
    @(negedge clk);
    while (m_cnt != 0) @(negedge clk);
  endtask

  task automatic pulse(input bit s_sl, input bit s_st);
    while (m_cnt != 0) @(negedge clk);
    #1; sleep_s = s_sl; stop_s = s_st;
    @(negedge clk);
    #1; sleep_s = 0; stop_s = 0;
  endtask

  task automatic raise_irq(input bit a, input bit w);
    while (m_cnt != 0) @(negedge clk);
    #1; irq_a = a; irq_w = w;
    to_boundary();
    #1; irq_a = 0; irq_w = 0;
  endtask

  task automatic do_reset();
    #1; rst_n = 0;
    @(negedge clk);
    #1; rst_n = 1;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 0; sleep_s = 0; stop_s = 0; tmode = 0; lson = 0; dton = 0;
    irq_a = 0; irq_w = 0; stab = '0;
    repeat (3) @(negedge clk);
    #1; rst_n = 1;
    @(negedge clk);
    chk("R1 reset mode", mode_o, 3'd0);
    chk("R1 reset gates", dut_g(), 7'b1111100);

    // Sleep from active, held until boundary
    pulse(1, 0);
    chk("R11 strobe held", mode_o, 3'd0);
    to_boundary();
    chk("R2 standby mode", mode_o, 3'd1);
    chk("R2 standby gates", dut_g(), 7'b1101100);
    pulse(0, 1); to_boundary();
    chk("R3 stop ignored in standby", mode_o, 3'd1);
    raise_irq(1, 0);
    chk("R3 irq wakes standby", mode_o, 3'd0);

    // Direct-transfer flag outside subactive
    #1; dton = 1;
    pulse(1, 0); to_boundary();
    chk("R9 dton ignored in active", mode_o, 3'd1);
    raise_irq(1, 0);
    #1; dton = 0;

    // Simultaneous strobes, stop mode
    #1; tmode = 0;
    pulse(1, 1); to_boundary();
    chk("R12 stop wins", mode_o, 3'd2);
    chk("R4 stop gates", dut_g(), 7'b0100001);
    raise_irq(1, 1); to_boundary();
    chk("R4 irqs ignored in stop", mode_o, 3'd2);
    do_reset(); @(negedge clk);
    chk("R1 reset from stop", {mode_o, dut_g()}, {3'd0, 7'b1111100});

    // Watch mode and stabilisation wait
    #1; tmode = 1;
    pulse(0, 1); to_boundary();
    chk("R5 watch mode", mode_o, 3'd3);
    chk("R5 watch gates", dut_g(), 7'b0100110);
    raise_irq(1, 0);
    chk("R6 general irq ignored in watch", mode_o, 3'd3);
    #1; stab = 8'd5; lson = 0;
    raise_irq(0, 1);
    chk("R6 watch to active", mode_o, 3'd0);
    chk("R10 main on, cpu gated", {main_o, cpu_o}, 2'b10);
    to_boundary();
    chk("R10 still gated", cpu_o, 1'b0);
    to_boundary();
    chk("R10 cpu released", cpu_o, 1'b1);

    // Subactive paths
    pulse(0, 1); to_boundary();
    #1; lson = 1;
    raise_irq(0, 1);
    chk("R6 watch to subactive", mode_o, 3'd4);
    chk("R7 subactive gates", dut_g(), 7'b0111110);
    #1; lson = 0; dton = 1; stab = 8'd0;
    pulse(1, 0); to_boundary();
    chk("R8 direct transfer to active", mode_o, 3'd0);
    chk("R8 cpu gated one boundary", cpu_o, 1'b0);
    #1; dton = 0;
    pulse(0, 1); to_boundary();
    #1; lson = 1;
    raise_irq(0, 1);
    #1; lson = 0;
    pulse(1, 0); to_boundary();
    chk("R8 subactive to watch", mode_o, 3'd3);
    #1; lson = 1; dton = 1;
    raise_irq(0, 1);
    pulse(0, 1); to_boundary();
    chk("R8 lson set blocks direct", mode_o, 3'd3);

    // Constrained random traffic, checked each cycle by the model
    do_reset();
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      #1;
      sleep_s = ($urandom_range(15) == 0);
      stop_s  = ($urandom_range(23) == 0);
      if ($urandom_range(7) == 0) tmode = $urandom_range(1);
      if ($urandom_range(7) == 0) lson  = $urandom_range(1);
      if ($urandom_range(7) == 0) dton  = $urandom_range(1);
      irq_a = ($urandom_range(9) == 0);
      irq_w = ($urandom_range(11) == 0);
      if ($urandom_range(31) == 0) stab = WW'($urandom_range(15));
      if ($urandom_range(249) == 0) rst_n = 0;
      else rst_n = 1;
    end
    #1; rst_n = 1; sleep_s = 0; stop_s = 0;
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule